// File: doc/BRIEF.md
# Soft Mute and Constant-Data Mute Flag

This block sits in the PCM path of a multichannel audio converter, after sample alignment and before the interpolation filters. On every sample strobe it scales all channels by one shared gain. While the mute request is high, that gain steps down towards silence. When the request drops, the gain steps back up to unity. A full swing takes 256 sample periods, so the fade time follows the sample rate. If the request changes part way through a ramp, the ramp turns around from whatever gain it has reached.

The block also drives a mute flag for an external analog mute circuit. The flag rises when the whole frame has held the same constant value for longer than a set number of frames. The constant value is either every bit zero or every bit one. The flag also rises while another block reports a clock fault, which covers power-up and invalid clocks. A frame that is not constant clears the constant-data part of the flag at once.

Top module: `audio_softmute`

## Requirements
- R1: After reset, `pcm_o` is zero, `pcm_vld_o` is low, the gain is unity (256) and `mute_flag_o` is low while `clk_fault_i` is low.
- R2: One clock after a cycle with `frame_vld_i` high, `pcm_vld_o` is high. Channel c of `pcm_o` (bits c*SAMPLE_W and up) then equals the two's-complement sample times the gain in force at that strobe, shifted right arithmetically by 8 (rounding towards minus infinity). `pcm_vld_o` is low one clock after a cycle without a strobe.
- R3: At gain 256, every sample, including the most negative value, passes through unchanged.
- R4: While `mute_req_i` is high, each strobe lowers the gain by one until it reaches 0. Starting from unity, the 257th strobe and every later one produce all-zero outputs on all channels.
- R5: While `mute_req_i` is low, each strobe raises the gain by one until it reaches 256. A change of the request part way through a ramp continues from the current gain with no jump.
- R6: The gain changes only on strobes. Cycles without a strobe leave it unchanged, whatever the mute request does.
- R7: A frame is constant when all of its channels are all zeros, or when all of its channels are all ones. `mute_flag_o` goes high one clock after the (CONST_FRAMES+1)th consecutive constant frame of the same kind, and not before.
- R8: A constant frame of the other kind (zeros after ones, or ones after zeros) restarts the run at a count of one.
- R9: A non-constant frame (any other content, including a mix of zero and all-ones channels) clears the run. `mute_flag_o` is low one clock later unless `clk_fault_i` is high.
- R10: `mute_flag_o` is high in every cycle in which `clk_fault_i` is high, with no added latency.
- R11: The run counter saturates, so the flag stays high however long the same constant data continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mute_req_i | input | 1 | Soft mute request, 1 = fade to silence |
| frame_vld_i | input | 1 | Sample strobe, one cycle per frame |
| pcm_i | input | NUM_CH*SAMPLE_W | Input samples, channel c at bits c*SAMPLE_W upward |
| clk_fault_i | input | 1 | Clock invalid or power-up in progress |
| pcm_o | output | NUM_CH*SAMPLE_W | Attenuated samples, same packing |
| pcm_vld_o | output | 1 | Output samples updated this cycle |
| mute_flag_o | output | 1 | External mute circuit request |

## Verification
The bench tests the ends of the ramp. A design that stops at 255 instead of unity would shave one count off full-scale samples. One that wraps below zero would burst back to loud output after about 256 frames of mute. Reversing the request mid-ramp catches any design that reloads the gain instead of continuing from it. Extreme samples such as the most negative value expose truncation that rounds towards zero instead of towards minus infinity. For the flag, the bench places a frame exactly at the threshold and exactly one past it, which catches off-by-one errors. It switches from zeros to ones, which catches a counter that never restarts. It also feeds a run longer than the threshold and a mix of zero and all-ones channels, which catch a counter that wraps and a detector that judges each channel on its own.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    PAT_NONE = 2'd0,
    PAT_ZERO = 2'd1,
    PAT_ONES = 2'd2
  } const_pat_e;
endpackage

// File: rtl/sm_gain_ramp.sv
module sm_gain_ramp #(
  parameter int GAIN_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  output logic [GAIN_W:0]   gain_o
);
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;

  logic [GAIN_W:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= UNITY;
    end else if (step_i) begin
      if (mute_i && gain_q != '0)
        gain_q <= gain_q - 1'b1;
      else if (!mute_i && gain_q != UNITY)
        gain_q <= gain_q + 1'b1;
    end
  end

  assign gain_o = gain_q;

  // R6
  gain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(gain_q));
  // R4
  gain_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mute_i && gain_q != '0) |=> gain_q == (GAIN_W+1)'($past(gain_q) - 1'b1));
  // R5
  gain_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !mute_i && gain_q != UNITY) |=> gain_q == (GAIN_W+1)'($past(gain_q) + 1'b1));
  // R4
  gain_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_i && gain_q == '0) |=> gain_q == '0);
endmodule

// File: rtl/sm_scale.sv
module sm_scale #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [GAIN_W:0]     gain_i,
  output logic [SAMPLE_W-1:0] smp_o
);
  localparam int PROD_W = SAMPLE_W + GAIN_W + 2;
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;

  logic signed [PROD_W-1:0] smp_ext, gain_ext;
  logic [SAMPLE_W-1:0]      smp_q;

  always_comb begin
    smp_ext  = PROD_W'($signed(smp_i));
    gain_ext = PROD_W'({1'b0, gain_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      smp_q <= '0;
    else if (load_i)
      smp_q <= SAMPLE_W'((smp_ext * gain_ext) >>> GAIN_W);
  end

  assign smp_o = smp_q;

  // R3
  unity_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gain_i == UNITY) |=> smp_o == $past(smp_i));
  // R4
  zero_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && gain_i == '0) |=> smp_o == '0);
  // R2
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(smp_o));
endmodule

// File: rtl/sm_const_detect.sv
module sm_const_detect
  import sm_pkg::*;
#(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_W     = 24,
  parameter int CONST_FRAMES = 8192
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_vld_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] pcm_i,
  output logic                       hit_o
);
  localparam int CNT_W = $clog2(CONST_FRAMES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(CONST_FRAMES + 1);

  const_pat_e       new_pat, pat_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (pcm_i == '0)      new_pat = PAT_ZERO;
    else if (pcm_i == '1) new_pat = PAT_ONES;
    else                  new_pat = PAT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q <= PAT_NONE;
      cnt_q <= '0;
    end else if (frame_vld_i) begin
      if (new_pat == PAT_NONE) begin
        pat_q <= PAT_NONE;
        cnt_q <= '0;
      end else if (new_pat == pat_q) begin
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end else begin
        pat_q <= new_pat;
        cnt_q <= CNT_W'(1);
      end
    end
  end

  assign hit_o = (cnt_q == CNT_SAT);

  // R9
  clear_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && new_pat == PAT_NONE) |=> !hit_o);
  // R8
  restart_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && new_pat != PAT_NONE && new_pat != pat_q) |=> cnt_q == CNT_W'(1));
  // R11
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && frame_vld_i && new_pat == pat_q) |=> hit_o);
  // R7
  idle_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(cnt_q));
endmodule

// File: rtl/audio_softmute.sv
module audio_softmute #(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_W     = 24,
  parameter int GAIN_W       = 8,
  parameter int CONST_FRAMES = 8192
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       mute_req_i,
  input  logic                       frame_vld_i,
  input  logic [NUM_CH*SAMPLE_W-1:0] pcm_i,
  input  logic                       clk_fault_i,
  output logic [NUM_CH*SAMPLE_W-1:0] pcm_o,
  output logic                       pcm_vld_o,
  output logic                       mute_flag_o
);
  logic [GAIN_W:0] gain;
  logic            const_hit;
  logic            vld_q;

  sm_gain_ramp #(.GAIN_W(GAIN_W)) i_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (frame_vld_i),
    .mute_i (mute_req_i),
    .gain_o (gain)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sm_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) i_scale (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (frame_vld_i),
      .smp_i  (pcm_i[c*SAMPLE_W +: SAMPLE_W]),
      .gain_i (gain),
      .smp_o  (pcm_o[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  sm_const_detect #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .CONST_FRAMES(CONST_FRAMES)
  ) i_detect (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_vld_i (frame_vld_i),
    .pcm_i       (pcm_i),
    .hit_o       (const_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= frame_vld_i;
  end

  assign pcm_vld_o   = vld_q;
  // fault path stays combinational so an unstable clock cannot delay it
  assign mute_flag_o = clk_fault_i | const_hit;

  // R2
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> pcm_vld_o);
  // R2
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> !pcm_vld_o);
  // R9
  flag_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld_i && pcm_i != '0 && pcm_i != '1 && !clk_fault_i) |=> (mute_flag_o == clk_fault_i));
endmodule

// File: tb/test_audio_softmute.sv
module test_audio_softmute;
  localparam int NC = 3;
  localparam int SW = 16;
  localparam int NF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mute = 1'b0;
  logic vld = 1'b0;
  logic fault = 1'b0;
  logic [NC*SW-1:0] pcm = '0;
  logic [NC*SW-1:0] pcm_o;
  logic pcm_vld_o, mute_flag_o;

  int checks = 0;
  int errors = 0;
  int g = 256;
  bit done = 0;

  always #10 clk = ~clk;

  audio_softmute #(.NUM_CH(NC), .SAMPLE_W(SW), .GAIN_W(8), .CONST_FRAMES(NF)) i_audio_softmute (
    .clk_i(clk), .rst_ni(rst_n), .mute_req_i(mute), .frame_vld_i(vld), .pcm_i(pcm),
    .clk_fault_i(fault), .pcm_o(pcm_o), .pcm_vld_o(pcm_vld_o), .mute_flag_o(mute_flag_o)
  );

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] smp(input int i, input int c);
    case (i % 11)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return (c == 0) ? 16'hffff : 16'h0001;
      default: return 16'((i * 40503 + c * 9973 + 17) ^ (i << 3));
    endcase
  endfunction

  function automatic logic [SW-1:0] scaled(input logic [SW-1:0] s, input int gain);
    int p;
    p = int'($signed(s)) * gain;
    return 16'(p >>> 8);
  endfunction

  task automatic send(input logic [NC*SW-1:0] f, input string tag);
    @(negedge clk);
    pcm = f;
    vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0;
    check(pcm_vld_o == 1'b1, "R2", "pcm_vld_o after strobe", int'(pcm_vld_o), 1);
    for (int c = 0; c < NC; c++) begin
      logic [SW-1:0] e;
      e = scaled(f[c*SW +: SW], g);
      check(pcm_o[c*SW +: SW] == e, tag, $sformatf("ch%0d gain %0d", c, g),
            int'($signed(pcm_o[c*SW +: SW])), int'($signed(e)));
    end
    if (mute && g > 0) g--;
    else if (!mute && g < 256) g++;
  endtask

  task automatic send_idx(input int i, input string tag);
    logic [NC*SW-1:0] f;
    for (int c = 0; c < NC; c++) f[c*SW +: SW] = smp(i, c);
    send(f, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pcm_o == '0, "R1", "pcm_o after reset", int'(pcm_o[SW-1:0]), 0);
    check(pcm_vld_o == 1'b0, "R1", "pcm_vld_o after reset", int'(pcm_vld_o), 0);
    check(mute_flag_o == 1'b0, "R1", "mute_flag_o after reset", int'(mute_flag_o), 0);

    // R3: unity sweep over extremes and mixed values
    for (int i = 0; i < 40; i++) send_idx(i, "R3");
    @(negedge clk);
    check(pcm_vld_o == 1'b0, "R2", "pcm_vld_o idle", int'(pcm_vld_o), 0);

    // R6: request toggles with no strobe, gain must stay at unity
    mute = 1'b1;
    repeat (12) @(negedge clk);
    mute = 1'b0;
    repeat (3) @(negedge clk);
    mute = 1'b1;
    send_idx(1, "R6");

    // R4: full fade and beyond
    for (int i = 0; i < 300; i++) send_idx(i + 3, "R4");
    check(g == 0, "R4", "model gain at floor", g, 0);
    send_idx(1, "R4");

    // R5: partial rise, reversal, full rise
    mute = 1'b0;
    for (int i = 0; i < 100; i++) send_idx(i + 7, "R5");
    mute = 1'b1;
    for (int i = 0; i < 40; i++) send_idx(i + 9, "R5");
    mute = 1'b0;
    for (int i = 0; i < 230; i++) send_idx(i + 5, "R5");
    check(g == 256, "R5", "model gain at unity", g, 256);

    // R7: zero run, threshold and one past
    for (int k = 1; k <= NF; k++) begin
      send('0, "R7");
      check(mute_flag_o == 1'b0, "R7", $sformatf("flag after %0d zero frames", k), int'(mute_flag_o), 0);
    end
    send('0, "R7");
    check(mute_flag_o == 1'b1, "R7", "flag past threshold", int'(mute_flag_o), 1);

    // R11: long run keeps the flag
    for (int k = 0; k < 3 * NF; k++) send('0, "R11");
    check(mute_flag_o == 1'b1, "R11", "flag after long run", int'(mute_flag_o), 1);

    // R9: mixed zero and all-ones channels count as non-constant
    send({{SW{1'b1}}, {(NC-1)*SW{1'b0}}}, "R9");
    check(mute_flag_o == 1'b0, "R9", "flag after mixed frame", int'(mute_flag_o), 0);

    // R8: zeros then switch to ones restarts the run
    for (int k = 0; k < NF; k++) send('0, "R8");
    for (int k = 1; k <= NF; k++) begin
      send('1, "R8");
      check(mute_flag_o == 1'b0, "R8", $sformatf("flag after %0d ones frames", k), int'(mute_flag_o), 0);
    end
    send('1, "R8");
    check(mute_flag_o == 1'b1, "R8", "flag on ones run", int'(mute_flag_o), 1);

    // R9: ordinary frame clears
    send_idx(4, "R9");
    check(mute_flag_o == 1'b0, "R9", "flag after data frame", int'(mute_flag_o), 0);

    // R10: clock fault forces the flag in the same cycle
    @(negedge clk);
    fault = 1'b1;
    #1;
    check(mute_flag_o == 1'b1, "R10", "flag during fault", int'(mute_flag_o), 1);
    send_idx(5, "R10");
    check(mute_flag_o == 1'b1, "R10", "flag during fault after frame", int'(mute_flag_o), 1);
    fault = 1'b0;
    #1;
    check(mute_flag_o == 1'b0, "R10", "flag after fault", int'(mute_flag_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule